// File: doc/BRIEF.md
# Flash Data-Polling Status Controller

This block runs on the host side of a parallel NOR flash. It follows a program or erase operation that has already been started, and decides when that operation has finished. After a start request it repeatedly reads one flash location through a synchronous request/acknowledge read port. Only the most significant data bit of each read is examined. For a program, that bit reads as the complement of the intended bit while the device is busy. For an erase, it reads 0 while busy and 1 once the erase is finished.

When the status bit shows completion, the controller does not yet trust the low bits. During the last moments of an operation the top bit can become true data while the other bits still carry status. The controller therefore issues one more full read of the location and judges the result on that word only. A program must read back exactly the intended byte. An erase must read back all ones, which also catches an erase aimed at protected sectors that fell back to read mode. If polling still shows busy once a cycle budget has run out, the controller gives up and reports a timeout.

Software or a sequencer issues the command writes to the flash first. It then pulses `start_i` with the operation type, an address inside the affected region and, for a program, the intended byte. It then waits for one of the three result pulses.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While `rst_ni` is low and after reset until a start, `busy_o`, `rd_req_o`, `done_o`, `err_o` and `timeout_o` are all 0.
- R2: `start_i` is accepted only while `busy_o` is 0. A start pulse while busy changes neither the polled address, the operation type nor the intended data.
- R3: `rd_req_o` stays high, with `rd_addr_o` unchanged, until the cycle in which `rd_ack_i` is high, and `rd_data_i` is taken in that cycle. Every read of one operation uses the `addr_i` value captured at start.
- R4: After a poll read that shows busy, `rd_req_o` stays low for exactly GAP_CYC+2 cycles before the next request.
- R5: Program (`op_erase_i`=0): a poll read is busy while data bit 7 differs from bit 7 of `data_i`, and complete when they are equal.
- R6: Erase (`op_erase_i`=1): a poll read is busy while data bit 7 is 0, and complete when it is 1.
- R7: After a completing poll read, the confirm read is requested after exactly one low cycle. Bits 6..0 of the completing poll read have no effect on the result.
- R8: For a program, the result is `done_o` if the confirm word equals the intended byte, and `err_o` otherwise.
- R9: For an erase, the result is `done_o` if the confirm word is all ones (8'hFF), and `err_o` otherwise.
- R10: If a poll read shows busy once at least TIMEOUT_CYC cycles have passed since the start, `timeout_o` pulses and no confirm read is made. A timeout never comes earlier than that.
- R11: Exactly one of `done_o`/`err_o`/`timeout_o` pulses for one cycle per operation. `done_o` and `err_o` come in the cycle after the confirm acknowledge, and `busy_o` is 0 in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start polling request |
| op_erase_i | input | 1 | Operation type: 1 erase, 0 program |
| addr_i | input | AW | Address to poll |
| data_i | input | DW | Intended program byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Confirm-word mismatch pulse |
| timeout_o | output | 1 | Timeout pulse |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data |

## Verification
A behavioural flash model acknowledges each read two falling edges after it sees the request. It stamps the cycle of every acknowledge and measures how long the request stays low between reads. A busy poll must be followed by a gap of exactly GAP_CYC+2 cycles, and a completing poll by a single low cycle before the confirm read. `done_o` and `err_o` must appear exactly one cycle after the confirm acknowledge, and `busy_o` must be 0 one cycle after that. A timeout must land between TIMEOUT_CYC and TIMEOUT_CYC+20 cycles after start. All outputs are sampled on the falling edge, so each of these timings is checked as an exact difference of cycle counts.

// File: rtl/flash_poll_pkg.sv
`timescale 1ns/1ps
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_READ,
    ST_WAIT_DATA,
    ST_EVALUATE,
    ST_CONFIRM_READ,
    ST_DONE,
    ST_ERROR
  } poll_state_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } poll_op_e;
endpackage

// File: rtl/poll_judge.sv
`timescale 1ns/1ps
module poll_judge import flash_poll_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input  poll_op_e        op_i,
  input  logic [DW-1:0]   expect_i,
  input  logic [DW-1:0]   word_i,
  output logic            complete_o,
  output logic            match_o
);
  logic [DW-1:0] ref_word;

  // erase target is the erased state (all ones)
  assign ref_word   = (op_i == OP_ERASE) ? {DW{1'b1}} : expect_i;
  assign complete_o = (word_i[DW-1] == ref_word[DW-1]);
  assign match_o    = (word_i == ref_word);
endmodule

// File: rtl/poll_gap_timer.sv
`timescale 1ns/1ps
module poll_gap_timer #(
  parameter int unsigned GAP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic zero_o
);
  localparam int unsigned CW = (GAP_CYC > 0) ? $clog2(GAP_CYC + 1) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? CW'(GAP_CYC) : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/poll_watchdog.sv
`timescale 1ns/1ps
module poll_watchdog #(
  parameter int unsigned LIMIT = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != TW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/flash_poll_ctrl.sv
`timescale 1ns/1ps
module flash_poll_ctrl import flash_poll_pkg::*; #(
  parameter int unsigned AW          = 24,
  parameter int unsigned DW          = 8,
  parameter int unsigned GAP_CYC     = 4,
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          timeout_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i
);
  poll_state_e   state_q, state_d;
  poll_op_e      op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic          poll_ok_q;
  logic          to_q;

  logic gap_load, gap_long, gap_zero;
  logic wd_clear, wd_expired;
  logic rd_complete, rd_match;
  logic accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  poll_judge #(.DW(DW)) u_judge (
    .op_i       (op_q),
    .expect_i   (exp_q),
    .word_i     (rd_data_i),
    .complete_o (rd_complete),
    .match_o    (rd_match)
  );

  poll_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .long_i (gap_long),
    .zero_o (gap_zero)
  );

  poll_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (wd_clear),
    .run_i     (busy_o),
    .expired_o (wd_expired)
  );

  always_comb begin
    state_d  = state_q;
    gap_load = 1'b0;
    gap_long = 1'b0;
    wd_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_ISSUE_READ;
          gap_load = 1'b1;
          wd_clear = 1'b1;
        end
      end
      ST_ISSUE_READ: if (gap_zero) state_d = ST_WAIT_DATA;
      ST_WAIT_DATA:  if (rd_ack_i) state_d = ST_EVALUATE;
      ST_EVALUATE: begin
        if (poll_ok_q) begin
          state_d = ST_CONFIRM_READ;
        end else if (wd_expired) begin
          state_d = ST_ERROR;
        end else begin
          state_d  = ST_ISSUE_READ;
          gap_load = 1'b1;
          gap_long = 1'b1;
        end
      end
      ST_CONFIRM_READ: if (rd_ack_i) state_d = rd_match ? ST_DONE : ST_ERROR;
      ST_DONE:         state_d = ST_IDLE;
      ST_ERROR:        state_d = ST_IDLE;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_PROGRAM;
      addr_q    <= '0;
      exp_q     <= '0;
      poll_ok_q <= 1'b0;
      to_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= poll_op_e'(op_erase_i);
        addr_q <= addr_i;
        exp_q  <= data_i;
      end
      if (state_q == ST_WAIT_DATA && rd_ack_i) poll_ok_q <= rd_complete;
      // remember why ERROR was entered
      if (state_q == ST_EVALUATE)     to_q <= 1'b1;
      if (state_q == ST_CONFIRM_READ) to_q <= 1'b0;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rd_req_o  = (state_q == ST_WAIT_DATA) || (state_q == ST_CONFIRM_READ);
  assign rd_addr_o = addr_q;
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = (state_q == ST_ERROR) && !to_q;
  assign timeout_o = (state_q == ST_ERROR) && to_q;
endmodule

module flash_poll_ctrl_chk #(
  parameter int unsigned AW          = 24,
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          timeout_o,
  input logic          rd_req_o,
  input logic          rd_ack_i,
  input logic [AW-1:0] rd_addr_o
);
  logic [31:0] run_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q <= '0;
    end else if (start_i && !busy_o) begin
      run_cnt_q <= '0;
    end else if (busy_o && run_cnt_q != 32'hFFFF_FFFF) begin
      run_cnt_q <= run_cnt_q + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(rd_req_o || done_o || err_o || timeout_o));

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);

  assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

  assert_result_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, timeout_o}));

  assert_result_after_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> $past(rd_ack_i && rd_req_o));

  assert_result_ends_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o || timeout_o) |=> !busy_o);

  assert_no_early_timeout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (run_cnt_q >= TIMEOUT_CYC));
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.AW(AW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .timeout_o (timeout_o),
  .rd_req_o  (rd_req_o),
  .rd_ack_i  (rd_ack_i),
  .rd_addr_o (rd_addr_o)
);

// File: tb/test_flash_poll_ctrl.sv
`timescale 1ns/1ps
module test_flash_poll_ctrl;
  localparam int AW  = 16;
  localparam int GAP = 3;
  localparam int TMO = 400;
  localparam int NV  = 9;

  typedef struct packed {
    logic       erase;
    logic [7:0] exp;
    logic [7:0] busy;
    logic       trans;
    logic [7:0] fin;
    logic [1:0] res;   // 0 done, 1 err, 2 timeout
    logic [7:0] reads;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h5A, 8'd3, 1'b0, 8'h5A, 2'd0, 8'd5},
    '{1'b0, 8'hC3, 8'd4, 1'b1, 8'hC3, 2'd0, 8'd6},
    '{1'b0, 8'h81, 8'd0, 1'b0, 8'h81, 2'd0, 8'd2},
    '{1'b0, 8'h9E, 8'd2, 1'b0, 8'h96, 2'd1, 8'd4},
    '{1'b0, 8'h70, 8'd2, 1'b0, 8'hF0, 2'd2, 8'd0},
    '{1'b1, 8'h00, 8'd5, 1'b1, 8'hFF, 2'd0, 8'd7},
    '{1'b1, 8'h00, 8'd1, 1'b0, 8'hFE, 2'd1, 8'd3},
    '{1'b1, 8'h00, 8'd3, 1'b0, 8'h3C, 2'd2, 8'd0},
    '{1'b1, 8'h00, 8'd0, 1'b0, 8'hFF, 2'd0, 8'd2}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          op_erase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic          busy_o, done_o, err_o, timeout_o, rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i = 1'b0;
  logic [7:0]    rd_data_i = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // flash model configuration (written by stimulus only)
  int            m_busy = 0;
  logic          m_trans = 1'b0;
  logic [7:0]    m_final = '0;
  logic          m_erase = 1'b0;
  logic [7:0]    m_exp = '0;
  logic [AW-1:0] m_addr = '0;
  // flash model observations (written by model only)
  int   m_reads = 0, m_max_gap = 0, m_last_gap = 0, m_ack_cyc = 0;
  int   m_lat = 0, m_low = 0;
  logic m_in_gap = 1'b0, m_addr_bad = 1'b0;

  flash_poll_ctrl #(.AW(AW), .DW(8), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) i_flash_poll_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_erase_i(op_erase_i),
    .addr_i(addr_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .timeout_o(timeout_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [7:0] flash_word(input int k);
    logic [6:0] junk;
    junk = 7'h55 ^ 7'(k);
    if (k < m_busy) return {(m_erase ? 1'b0 : ~m_exp[7]), junk};
    if (k == m_busy && m_trans) return {m_final[7], 7'h2A ^ m_final[6:0]};
    return m_final;
  endfunction

  always @(negedge clk_i) begin
    if (start_i && !busy_o) begin
      m_reads = 0; m_max_gap = 0; m_last_gap = 0; m_lat = 0; m_low = 0;
      m_in_gap = 1'b0; m_addr_bad = 1'b0;
    end
    if (rd_req_o) begin
      if (m_in_gap) begin
        m_last_gap = m_low;
        if (m_low > m_max_gap) m_max_gap = m_low;
        m_in_gap = 1'b0;
      end
    end else if (m_in_gap) begin
      m_low++;
    end
    if (rd_ack_i) begin
      rd_ack_i = 1'b0;
    end else if (rd_req_o) begin
      if (m_lat == 1) begin
        rd_ack_i  = 1'b1;
        rd_data_i = flash_word(m_reads);
        if (rd_addr_o != m_addr) m_addr_bad = 1'b1;
        m_reads++;
        m_lat = 0;
        m_low = 0;
        m_in_gap = 1'b1;
        m_ack_cyc = cyc;
      end else begin
        m_lat++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic er, input logic [7:0] ex, input logic [AW-1:0] ad,
                        input int bz, input logic tr, input logic [7:0] fn,
                        output int res, output int el, output int lat);
    int c0;
    m_busy = bz; m_trans = tr; m_final = fn; m_erase = er; m_exp = ex; m_addr = ad;
    @(posedge clk_i); #2;
    start_i = 1'b1; op_erase_i = er; addr_i = ad; data_i = ex;
    c0 = cyc;
    @(posedge clk_i); #2;
    start_i = 1'b0;
    res = -1; el = 0; lat = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      if (done_o) res = 0;
      else if (err_o) res = 1;
      else if (timeout_o) res = 2;
      if (res >= 0) begin
        el = cyc - c0;
        lat = cyc - m_ack_cyc;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int res, el, lat;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 outputs in reset", {rd_req_o, done_o, err_o, timeout_o}, 0);
    @(posedge clk_i); #2 rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 req after reset", rd_req_o, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].erase, VECS[i].exp, AW'(16'h1000 + i * 16'h0111), int'(VECS[i].busy),
             VECS[i].trans, VECS[i].fin, res, el, lat);
      // R5 R6 R8 R9 R10: outcome from polarity and confirm word
      chk($sformatf("R8/R9/R10 result vec %0d", i), res, int'(VECS[i].res));
      chk($sformatf("R3 address vec %0d", i), m_addr_bad, 0);
      if (VECS[i].res != 2'd2) begin
        chk($sformatf("R5/R6 read count vec %0d", i), m_reads, int'(VECS[i].reads));
        chk($sformatf("R7 confirm gap vec %0d", i), m_last_gap, 1);
        chk($sformatf("R11 result latency vec %0d", i), lat, 1);
      end else begin
        chk($sformatf("R10 timeout not early vec %0d", i), int'(el >= TMO), 1);
        chk($sformatf("R10 timeout bounded vec %0d", i), int'(el <= TMO + 20), 1);
        chk($sformatf("R10 no confirm vec %0d", i), m_last_gap, GAP + 2);
      end
      if (VECS[i].busy != 8'd0) chk($sformatf("R4 poll gap vec %0d", i), m_max_gap, GAP + 2);
      @(negedge clk_i);
      chk($sformatf("R11 idle after result vec %0d", i), busy_o, 0);
    end

    // R2: start while busy ignored
    fork
      run_op(1'b0, 8'h3C, 16'h0400, 6, 1'b0, 8'h3C, res, el, lat);
      begin
        repeat (12) @(posedge clk_i);
        #2;
        start_i = 1'b1; op_erase_i = 1'b1; addr_i = 16'h7777; data_i = 8'h00;
        @(posedge clk_i); #2;
        start_i = 1'b0;
      end
    join
    chk("R2 result unchanged", res, 0);
    chk("R2 address unchanged", m_addr_bad, 0);
    chk("R2 read count unchanged", m_reads, 8);
    @(negedge clk_i);
    chk("R2 idle afterwards", busy_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule